// File: doc/BRIEF.md
# Separate-Port Four-Beat Double-Rate SRAM

This block is an on-chip memory with a read data port and a write data port that never share wires, so a read burst and a write burst can be in flight in the same cycles. One address bus serves both ports by time sharing. A single clock runs at twice the rate of the notional memory clock, and each of its rising edges is one half-period of that memory clock. An internal phase bit, brought out as `k_phase`, marks whether the coming edge is a "K" edge, where a read request is taken, or a "K#" edge, where a write request is taken.

Every address selects a group of four consecutive words. A request moves all four, one word per edge, in ascending order. Write words carry active-low lane enables so single bytes can be updated. A completed write burst is committed to the array one edge after its last word arrives. A read that falls into that gap is served from the pending burst, so reads always return the newest data.

Top module: `sdp_b4_sram`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `rvalid` is 0, `rdata` is 0 and `k_phase` is 1.
- R2: `k_phase` inverts on every clock edge after reset. It is 1 in the cycle before a K edge.
- R3: If `rd_sel_n` is 0 at a K edge e while the read port is idle, `addr` is taken as a read group. `rvalid` is then 1 in the four cycles after edges e+3 to e+6, and after edge e+3+k `rdata` carries word 4*addr+k (k = 0..3).
- R4: If `wr_sel_n` is 0 at a K# edge w while the write port is idle, `addr` is taken as a write group. `wdata` and `wlane_n` sampled at edges w+1 to w+4 are beats 0 to 3, and they are destined for words 4*addr+0 to 4*addr+3.
- R5: Lane i of a word is bits [i*LW +: LW], with LW = 8 when DW = 8 and LW = 9 otherwise. A 1 on `wlane_n[i]` leaves lane i of the stored word unchanged. A 0 replaces it.
- R6: `rd_sel_n` has no effect at K# edges, and `wr_sel_n` has no effect at K edges.
- R7: A port counts as busy at the three edges that follow its accepted request. A select at such an edge is ignored. A request at the fourth edge is accepted, which gives back-to-back bursts.
- R8: The word that a read sends out after edge t includes every write burst whose last beat was sampled at an edge before t. This holds even when that burst has not yet been committed to the array.
- R9: Whenever `rvalid` is 0, `rdata` is 0.
- R10: A read burst and a write burst to the same group may overlap in time, and both complete without stalling each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the memory-clock rate; every rising edge is one beat |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read request, sampled at K edges |
| wr_sel_n | input | 1 | Active-low write request, sampled at K# edges |
| addr | input | AW | Shared group address: read group at K edges, write group at K# edges |
| wdata | input | DW | Write word for the current beat |
| wlane_n | input | NB | Active-low lane write enables for the current beat |
| k_phase | output | 1 | 1 when the coming edge is a K edge |
| rdata | output | DW | Read word, 0 when not valid |
| rvalid | output | 1 | High for each of the four read beats |

## Verification
A read taken at edge e puts its first word on the outputs three edges later, at edge e+3, and the other words follow at one word per edge. A write becomes visible to a read word that is fetched at any edge after the write's fourth data beat. The bench runs an edge-by-edge model that uses exactly these offsets: it puts each read word into a slot for edge e+3+k and folds each finished write into its reference memory right after that edge's read slot is evaluated. It then compares `rvalid`, `rdata` and `k_phase` one time unit after every edge. Selects are held low across both phases and pulsed in pseudo-random patterns, so ignored requests, back-to-back bursts and same-group overlaps at many offsets are all covered by the same comparison.

// File: rtl/sdp_b4_pkg.sv
package sdp_b4_pkg;
   localparam int unsigned BEATS  = 4;
   localparam int unsigned BEAT_W = 2;
   typedef logic [BEAT_W-1:0] beat_t;

   // byte lanes: 9-bit lanes when the width is a multiple of nine, else one lane
   function automatic int unsigned lane_count(input int unsigned dw);
      return (dw % 9 == 0) ? dw / 9 : 1;
   endfunction

   function automatic int unsigned lane_width(input int unsigned dw);
      return dw / lane_count(dw);
   endfunction
endpackage

// File: rtl/sdp_b4_port_seq.sv
module sdp_b4_port_seq
   import sdp_b4_pkg::*;
#(
   parameter int unsigned AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          slot_i,
   input  logic          sel_n_i,
   input  logic [AW-1:0] addr_i,
   output logic          start_o,
   output logic          run_o,
   output beat_t         beat_o,
   output logic [AW-1:0] addr_o
);
   logic          run_q;
   beat_t         beat_q;
   logic [AW-1:0] addr_q;
   logic          last_beat;

   assign last_beat = (beat_q == beat_t'(BEATS - 1));
   assign start_o   = slot_i & ~sel_n_i & (~run_q | last_beat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         beat_q <= '0;
         addr_q <= '0;
      end else if (start_o) begin
         run_q  <= 1'b1;
         beat_q <= '0;
         addr_q <= addr_i;
      end else if (run_q) begin
         beat_q <= beat_q + beat_t'(1);
         run_q  <= ~last_beat;
      end
   end

   assign run_o  = run_q;
   assign beat_o = beat_q;
   assign addr_o = addr_q;
endmodule

// File: rtl/sdp_b4_lane_merge.sv
module sdp_b4_lane_merge #(
   parameter int unsigned DW = 18,
   parameter int unsigned NB = 2
) (
   input  logic [DW-1:0] old_i,
   input  logic [DW-1:0] new_i,
   input  logic [NB-1:0] en_i,
   output logic [DW-1:0] out_o
);
   localparam int unsigned LW = DW / NB;

   generate
      if (NB == 1) begin : g_single
         assign out_o = en_i[0] ? new_i : old_i;
      end else begin : g_lanes
         for (genvar i = 0; i < NB; i++) begin : g_lane
            assign out_o[i*LW +: LW] = en_i[i] ? new_i[i*LW +: LW] : old_i[i*LW +: LW];
         end
      end
   endgenerate
endmodule

// File: rtl/sdp_b4_wr_asm.sv
module sdp_b4_wr_asm
   import sdp_b4_pkg::*;
#(
   parameter int unsigned DW = 18,
   parameter int unsigned AW = 4,
   parameter int unsigned NB = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       run_i,
   input  beat_t                      beat_i,
   input  logic [AW-1:0]              addr_i,
   input  logic [DW-1:0]              data_i,
   input  logic [NB-1:0]              lane_n_i,
   output logic                       pend_o,
   output logic [AW-1:0]              paddr_o,
   output logic [BEATS-1:0][DW-1:0]   word_o,
   output logic [BEATS-1:0][NB-1:0]   lane_en_o
);
   logic                     pend_q;
   logic [AW-1:0]            paddr_q;
   logic [BEATS-1:0][DW-1:0] word_q;
   logic [BEATS-1:0][NB-1:0] en_q;
   logic                     final_beat;

   assign final_beat = run_i & (beat_i == beat_t'(BEATS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         paddr_q <= '0;
         word_q  <= '0;
         en_q    <= '0;
      end else begin
         pend_q <= final_beat;
         if (run_i) begin
            word_q[beat_i] <= data_i;
            en_q[beat_i]   <= ~lane_n_i;
         end
         if (final_beat) paddr_q <= addr_i;
      end
   end

   assign pend_o    = pend_q;
   assign paddr_o   = paddr_q;
   assign word_o    = word_q;
   assign lane_en_o = en_q;
endmodule

// File: rtl/sdp_b4_store.sv
module sdp_b4_store
   import sdp_b4_pkg::*;
#(
   parameter int unsigned DW = 18,
   parameter int unsigned AW = 4,
   parameter int unsigned NB = 2,
   parameter int unsigned RD_DELAY = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_run_i,
   input  beat_t                    rd_beat_i,
   input  logic [AW-1:0]            rd_addr_i,
   input  logic                     pend_i,
   input  logic [AW-1:0]            paddr_i,
   input  logic [BEATS-1:0][DW-1:0] pword_i,
   input  logic [BEATS-1:0][NB-1:0] pen_i,
   output logic [DW-1:0]            rdata_o,
   output logic                     rvalid_o
);
   localparam int unsigned WORDS = (1 << AW) * BEATS;
   localparam int unsigned IW    = AW + BEAT_W;

   logic [DW-1:0] mem [WORDS];

   // read control delay line
   logic          d_run  [RD_DELAY+1];
   beat_t         d_beat [RD_DELAY+1];
   logic [AW-1:0] d_addr [RD_DELAY+1];

   assign d_run[0]  = rd_run_i;
   assign d_beat[0] = rd_beat_i;
   assign d_addr[0] = rd_addr_i;

   generate
      for (genvar s = 1; s <= RD_DELAY; s++) begin : g_dly
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d_run[s]  <= 1'b0;
               d_beat[s] <= '0;
               d_addr[s] <= '0;
            end else begin
               d_run[s]  <= d_run[s-1];
               d_beat[s] <= d_beat[s-1];
               d_addr[s] <= d_addr[s-1];
            end
         end
      end
   endgenerate

   // commit of the pending burst
   logic [BEATS-1:0][DW-1:0] commit_w;
   generate
      for (genvar k = 0; k < BEATS; k++) begin : g_commit
         sdp_b4_lane_merge #(.DW(DW), .NB(NB)) u_merge (
            .old_i (mem[{paddr_i, beat_t'(k)}]),
            .new_i (pword_i[k]),
            .en_i  (pen_i[k]),
            .out_o (commit_w[k])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (pend_i) begin
         for (int k = 0; k < BEATS; k++) begin
            mem[{paddr_i, beat_t'(k)}] <= commit_w[k];
         end
      end
   end

   // fetch with forwarding from the pending burst
   logic          f_run;
   beat_t         f_beat;
   logic [AW-1:0] f_addr;
   logic [IW-1:0] f_idx;
   logic [DW-1:0] f_base;
   logic [DW-1:0] f_fwd;
   logic [DW-1:0] f_word;
   logic          f_hit;

   assign f_run  = d_run[RD_DELAY];
   assign f_beat = d_beat[RD_DELAY];
   assign f_addr = d_addr[RD_DELAY];
   assign f_idx  = {f_addr, f_beat};
   assign f_base = mem[f_idx];
   assign f_hit  = pend_i & (paddr_i == f_addr);

   sdp_b4_lane_merge #(.DW(DW), .NB(NB)) u_fwd (
      .old_i (f_base),
      .new_i (pword_i[f_beat]),
      .en_i  (pen_i[f_beat]),
      .out_o (f_fwd)
   );

   assign f_word = f_hit ? f_fwd : f_base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_o <= 1'b0;
         rdata_o  <= '0;
      end else begin
         rvalid_o <= f_run;
         rdata_o  <= f_run ? f_word : '0;
      end
   end
endmodule

// File: rtl/sdp_b4_sram.sv
module sdp_b4_sram
   import sdp_b4_pkg::*;
#(
   parameter  int unsigned DW = 18,
   parameter  int unsigned AW = 4,
   localparam int unsigned NB = sdp_b4_pkg::lane_count(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_sel_n,
   input  logic          wr_sel_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [NB-1:0] wlane_n,
   output logic          k_phase,
   output logic [DW-1:0] rdata,
   output logic          rvalid
);
   generate
      if (!(DW == 8 || DW == 9 || DW == 18 || DW == 36)) begin : g_bad_width
         $fatal(1, "sdp_b4_sram: DW must be 8, 9, 18 or 36");
      end
      if (AW < 1 || AW > 16) begin : g_bad_depth
         $fatal(1, "sdp_b4_sram: AW must lie in 1..16");
      end
   endgenerate

   logic ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= 1'b1;
      else        ph_q <= ~ph_q;
   end

   assign k_phase = ph_q;

   logic          rd_start, rd_run;
   beat_t         rd_beat;
   logic [AW-1:0] rd_addr;
   logic          wr_start, wr_run;
   beat_t         wr_beat;
   logic [AW-1:0] wr_addr;

   sdp_b4_port_seq #(.AW(AW)) u_rd_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .slot_i  (ph_q),
      .sel_n_i (rd_sel_n),
      .addr_i  (addr),
      .start_o (rd_start),
      .run_o   (rd_run),
      .beat_o  (rd_beat),
      .addr_o  (rd_addr)
   );

   sdp_b4_port_seq #(.AW(AW)) u_wr_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .slot_i  (~ph_q),
      .sel_n_i (wr_sel_n),
      .addr_i  (addr),
      .start_o (wr_start),
      .run_o   (wr_run),
      .beat_o  (wr_beat),
      .addr_o  (wr_addr)
   );

   logic                     pend;
   logic [AW-1:0]            paddr;
   logic [BEATS-1:0][DW-1:0] pword;
   logic [BEATS-1:0][NB-1:0] pen;

   sdp_b4_wr_asm #(.DW(DW), .AW(AW), .NB(NB)) u_wr_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (wr_run),
      .beat_i    (wr_beat),
      .addr_i    (wr_addr),
      .data_i    (wdata),
      .lane_n_i  (wlane_n),
      .pend_o    (pend),
      .paddr_o   (paddr),
      .word_o    (pword),
      .lane_en_o (pen)
   );

   sdp_b4_store #(.DW(DW), .AW(AW), .NB(NB), .RD_DELAY(2)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_run_i  (rd_run),
      .rd_beat_i (rd_beat),
      .rd_addr_i (rd_addr),
      .pend_i    (pend),
      .paddr_i   (paddr),
      .pword_i   (pword),
      .pen_i     (pen),
      .rdata_o   (rdata),
      .rvalid_o  (rvalid)
   );
endmodule

// File: rtl/sdp_b4_sram_chk.sv
module sdp_b4_sram_chk #(
   parameter int unsigned DW = 18
) (
   input logic          clk,
   input logic          rst_n,
   input logic          k_phase,
   input logic          rvalid,
   input logic [DW-1:0] rdata,
   input logic          rd_start,
   input logic          wr_start
);
   logic [1:0] vcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vcnt <= '0;
      else if (rvalid) vcnt <= vcnt + 2'd1;
      else             vcnt <= '0;
   end

   a_r2_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (k_phase != $past(k_phase)));

   a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      rd_start |-> ##4 rvalid);

   a_r3_beats_of_four: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rvalid) |-> (vcnt == 2'd0));

   a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rvalid |-> (rdata == '0));

   a_r7_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      rd_start |-> ##2 !rd_start);

   a_r7_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |-> ##2 !wr_start);
endmodule

bind sdp_b4_sram sdp_b4_sram_chk #(.DW(DW)) u_sdp_b4_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .k_phase  (k_phase),
   .rvalid   (rvalid),
   .rdata    (rdata),
   .rd_start (rd_start),
   .wr_start (wr_start)
);

// File: tb/test_sdp_b4_sram.sv
module test_sdp_b4_sram;
   localparam int DW = 18;
   localparam int AW = 4;
   localparam int NB = 2;
   localparam int LW = 9;
   localparam int NW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_sel_n = 1'b1;
   logic          wr_sel_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [NB-1:0] wlane_n = '0;
   logic          k_phase;
   logic [DW-1:0] rdata;
   logic          rvalid;

   always #2 clk = ~clk;

   sdp_b4_sram #(.DW(DW), .AW(AW)) i_sdp_b4_sram (
      .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
      .addr(addr), .wdata(wdata), .wlane_n(wlane_n),
      .k_phase(k_phase), .rdata(rdata), .rvalid(rvalid)
   );

   int n_chk = 0;
   int n_fail = 0;

   // model state
   int            t = 0;
   bit            mph = 1'b1;
   int            lr = -100, lw = -100;
   int            wa_cur = 0, wseed_cur = 0;
   int            rcount = 0, wcount = 0, rlim = 0, wlim = 0;
   bit            rd_on = 0, wr_on = 0, pulse = 0, same = 0, mask_on = 0;
   logic [DW-1:0] refm [NW];
   logic [DW-1:0] wbuf [4];
   logic [NB-1:0] wmsk [4];
   bit            sv [8];
   int            sa [8];
   logic [DW-1:0] erd;
   bit            erv;

   function automatic logic [31:0] hsh(input int x);
      logic [31:0] v;
      v = 32'(x) * 32'd1103515245 + 32'd12345;
      return v ^ (v >> 13);
   endfunction

   function automatic logic [DW-1:0] pat(input int a, input int k, input int s);
      return DW'((a * 4 + k) * 2731 + s * 977 + 5);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", req, what, act, exp_v, t);
      end
   endtask

   task automatic drive();
      int d;
      int ra, wa;
      logic [31:0] h;
      h = hsh(t);
      rd_sel_n = !(rd_on && rcount < rlim && (!pulse || h[3]));
      wr_sel_n = !(wr_on && wcount < wlim && (!pulse || h[5]));
      ra = same ? (t / 24) % 16 : rcount % 16;
      wa = same ? (t / 24) % 16 : wcount % 16;
      addr = mph ? AW'(ra) : AW'(wa);
      d = t - lw;
      if (d >= 1 && d <= 4) wdata = pat(wa_cur, d - 1, wseed_cur);
      else                  wdata = h[25:8];
      wlane_n = mask_on ? h[9:8] : 2'b00;
   endtask

   task automatic step(input string tag);
      int d, sl;
      @(posedge clk);
      sl = t % 8;
      if (sv[sl]) begin
         erv = 1'b1; erd = refm[sa[sl]]; sv[sl] = 1'b0;
      end else begin
         erv = 1'b0; erd = '0;
      end
      // write beat sampling; a finished burst becomes visible after this edge (R8)
      d = t - lw;
      if (d >= 1 && d <= 4) begin
         wbuf[d-1] = wdata;
         wmsk[d-1] = ~wlane_n;
         if (d == 4) begin
            for (int k = 0; k < 4; k++)
               for (int i = 0; i < NB; i++)
                  if (wmsk[k][i]) refm[wa_cur*4 + k][i*LW +: LW] = wbuf[k][i*LW +: LW];
         end
      end
      // write request: K# edges only (R6), not while busy (R7)
      if (!mph && !wr_sel_n && (t - lw) >= 4) begin
         lw = t; wa_cur = int'(addr); wseed_cur = wcount; wcount++;
      end
      // read request: K edges only (R6), not while busy (R7)
      if (mph && !rd_sel_n && (t - lr) >= 4) begin
         lr = t;
         for (int k = 0; k < 4; k++) begin
            sv[(t + 3 + k) % 8] = 1'b1;
            sa[(t + 3 + k) % 8] = int'(addr) * 4 + k;
         end
         rcount++;
      end
      mph = ~mph;
      t++;
      #1;
      check(k_phase === mph, "R2", "k_phase", DW'(k_phase), DW'(mph));
      if (erv) begin
         check(rvalid === 1'b1, tag, "rvalid", DW'(rvalid), DW'(1));
         check(rdata === erd, tag, "rdata", rdata, erd);
      end else begin
         check(rvalid === 1'b0, "R9", "rvalid", DW'(rvalid), DW'(0));
         check(rdata === '0, "R9", "rdata", rdata, '0);
      end
   endtask

   task automatic run(input int n, input string tag);
      for (int c = 0; c < n; c++) begin
         drive();
         step(tag);
      end
   endtask

   task automatic idle(input int n);
      rd_on = 0; wr_on = 0; pulse = 0; same = 0; mask_on = 0;
      run(n, "R9");
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(4 * 60000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < NW; i++) refm[i] = '0;
      for (int i = 0; i < 8; i++) begin sv[i] = 1'b0; sa[i] = 0; end
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check(rvalid === 1'b0, "R1", "rvalid in reset", DW'(rvalid), DW'(0));
      check(rdata === '0, "R1", "rdata in reset", rdata, '0);
      check(k_phase === 1'b1, "R1", "k_phase in reset", DW'(k_phase), DW'(1));
      rst_n = 1'b1;
      #1;
      check(rvalid === 1'b0, "R1", "rvalid after release", DW'(rvalid), DW'(0));
      check(k_phase === 1'b1, "R1", "k_phase after release", DW'(k_phase), DW'(1));

      // R4: fill every group with full-lane writes
      wr_on = 1; wlim = wcount + 16;
      run(72, "R4");
      idle(8);
      // R3: read every group back-to-back, selects held low in both phases (R6)
      rd_on = 1; rlim = rcount + 16;
      run(72, "R3,R4,R6");
      idle(8);
      // R5: lane-masked writes, then read back
      wr_on = 1; mask_on = 1; wlim = wcount + 16;
      run(72, "R5");
      mask_on = 0; wr_on = 0;
      rd_on = 1; rlim = rcount + 16;
      run(72, "R5");
      idle(8);
      // R8/R10: overlapping read and write bursts on the same group
      rd_on = 1; wr_on = 1; same = 1; mask_on = 1;
      rlim = rcount + 1000; wlim = wcount + 1000;
      run(400, "R8,R10");
      idle(12);
      // R7: pseudo-random select pulses, busy-port requests dropped
      rd_on = 1; wr_on = 1; pulse = 1; mask_on = 1;
      rlim = rcount + 100000; wlim = wcount + 100000;
      run(1200, "R7");
      same = 1;
      run(1200, "R7,R8");
      idle(12);

      summary();
      $finish;
   end
endmodule